// File: doc/BRIEF.md
# Interrupt Acknowledge CPU Interface

This block is the per-processor front end of an interrupt controller. It watches a pending vector delivered by a distributor, together with a priority value for every line. From the lines that are pending, not already in service, and more urgent than a programmable priority mask, it picks one winner. It raises an interrupt request toward its processor whenever such a winner exists and both the local enable and the distributor-wide enable are on.

Software talks to it through a small register port. Reading the acknowledge register returns the winner's ID and moves that line into service. While a line is in service it is not presented again. Writing the same word to the end-of-interrupt register ends service for that line. When nothing qualifies, the acknowledge read returns the reserved spurious ID 1023. For the sixteen software-generated IDs the acknowledged word also reports which processor raised the interrupt.

Top module: `ciack_top`

## Requirements
- R1: After reset the request output is low, the control and mask registers read as zero, and an acknowledge read returns 1023.
- R2: A line is eligible only when its pending input is 1, it is not in service, and its priority value is strictly lower than the mask. A priority equal to the mask does not qualify.
- R3: Among eligible lines the one with the numerically lowest priority value wins. On equal priority the lower ID wins.
- R4: A successful acknowledge word carries the ID in bits 9:0. For IDs 0 to 15, bits 12:10 carry that line's 3-bit source-processor field; for other IDs they are 0. Bits 31:13 are 0.
- R5: An acknowledge read returns exactly 1023, with bits 31:10 zero, when no line is eligible, when control bit 0 is 0, or when the distributor enable input is low. Such a read puts no line into service.
- R6: A successful acknowledge puts the returned line into service. That line is not selected, and does not raise the request, until its end-of-interrupt write.
- R7: A write to the end-of-interrupt register ends service for the ID in bits 9:0. Bits 12:10 are ignored. IDs that do not name an implemented line have no effect.
- R8: The request output is 1 exactly when an eligible line exists, control bit 0 is 1, and the distributor enable input is 1. It follows changes of the inputs in the same cycle.
- R9: The register map uses a 2-bit address: 0 is control (bit 0 only, other bits read 0), 1 is the 8-bit priority mask, 2 is acknowledge, and 3 is end-of-interrupt. Read data appears on the read-data port in the cycle after the read strobe and holds until the next read.
- R10: A write to the acknowledge address changes nothing. A read of the end-of-interrupt address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dist_en_i | input | 1 | Distributor-wide forwarding enable |
| pend_i | input | NUM_IRQ | Pending line per interrupt ID |
| prio_i | input | NUM_IRQ*PRIO_W | Priority value per ID, ID n at bits n*PRIO_W upward |
| sgi_src_i | input | 16*CPU_W | Source processor for IDs 0 to 15 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is a set of several lines in service at once, mixed with eligible lines at the same priority, so that the winner depends on both the service bits and the ID tie-break. The bench keeps its own model of which lines are in service. In random rounds it acknowledges lines without finishing them and retires a chosen in-service line only now and then. It draws priorities from a coarse set of values so that ties are common, and it checks every acknowledge against the model.

// File: rtl/ciack_pkg.sv
package ciack_pkg;
    localparam int ID_W     = 10;
    localparam int NUM_SGI  = 16;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_PMASK = 2'd1,
        ADDR_ACK   = 2'd2,
        ADDR_EOI   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/ciack_filter.sv
module ciack_filter #(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ-1:0]        active_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         pmask_i,
    output logic [NUM_IRQ-1:0]        elig_o
);
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        logic [PRIO_W-1:0] line_prio;
        assign line_prio = prio_i[g*PRIO_W +: PRIO_W];
        assign elig_o[g] = pend_i[g] && !active_i[g] && (line_prio < pmask_i);
    end
endmodule

// File: rtl/ciack_arbiter.sv
module ciack_arbiter
    import ciack_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_IRQ-1:0]        elig_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    output logic                      found_o,
    output logic [ID_W-1:0]           win_id_o
);
    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        found_o   = 1'b0;
        win_id_o  = SPURIOUS_ID;
        best_prio = '1;
        // scan from the top so that ties resolve toward the lower ID
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (elig_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] <= best_prio)) begin
                found_o   = 1'b1;
                best_prio = prio_i[i*PRIO_W +: PRIO_W];
                win_id_o  = ID_W'(i);
            end
        end
    end

    // R3
    always_comb begin
        if (found_o) begin
            winner_is_eligible_chk: assert (win_id_o < ID_W'(NUM_IRQ) && elig_i[win_id_o[$clog2(NUM_IRQ)-1:0]]);
        end
    end
endmodule

// File: rtl/ciack_top.sv
module ciack_top
    import ciack_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8,
    parameter int CPU_W   = 3
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      dist_en_i,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [NUM_SGI*CPU_W-1:0]  sgi_src_i,
    input  logic                      reg_wr_i,
    input  logic                      reg_rd_i,
    input  logic [1:0]                reg_addr_i,
    input  logic [31:0]               reg_wdata_i,
    output logic [31:0]               reg_rdata_o,
    output logic                      irq_o
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    typedef struct packed {
        logic               ctrl_en;
        logic [PRIO_W-1:0]  pmask;
        logic [NUM_IRQ-1:0] active;
        logic [31:0]        rdata;
        logic               ack_rd;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_IRQ-1:0] elig;
    logic               found;
    logic [ID_W-1:0]    win_id;
    logic               deliver;
    logic [CPU_W-1:0]   src_cpu;
    logic [31:0]        ack_word;
    logic [ID_W-1:0]    eoi_id;

    ciack_filter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) filter_i (
        .pend_i   (pend_i),
        .active_i (s_q.active),
        .prio_i   (prio_i),
        .pmask_i  (s_q.pmask),
        .elig_o   (elig)
    );

    ciack_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) arb_i (
        .elig_i   (elig),
        .prio_i   (prio_i),
        .found_o  (found),
        .win_id_o (win_id)
    );

    assign deliver = found && s_q.ctrl_en && dist_en_i;
    assign irq_o   = deliver;
    assign eoi_id  = reg_wdata_i[ID_W-1:0];

    always_comb begin
        src_cpu = '0;
        if (win_id < ID_W'(NUM_SGI)) begin
            src_cpu = sgi_src_i[win_id[3:0]*CPU_W +: CPU_W];
        end
        ack_word = {{(32-ID_W-CPU_W){1'b0}}, src_cpu, win_id};
    end

    always_comb begin
        s_d        = s_q;
        s_d.ack_rd = 1'b0;

        if (reg_wr_i) begin
            unique case (reg_addr_e'(reg_addr_i))
                ADDR_CTRL:  s_d.ctrl_en = reg_wdata_i[0];
                ADDR_PMASK: s_d.pmask   = reg_wdata_i[PRIO_W-1:0];
                ADDR_EOI: begin
                    for (int i = 0; i < NUM_IRQ; i++) begin
                        if (eoi_id == ID_W'(i)) s_d.active[i] = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (reg_rd_i) begin
            unique case (reg_addr_e'(reg_addr_i))
                ADDR_CTRL:  s_d.rdata = {31'b0, s_q.ctrl_en};
                ADDR_PMASK: s_d.rdata = {{(32-PRIO_W){1'b0}}, s_q.pmask};
                ADDR_ACK: begin
                    s_d.ack_rd = 1'b1;
                    if (deliver) begin
                        s_d.rdata = ack_word;
                        s_d.active[win_id[IDX_W-1:0]] = 1'b1;
                    end else begin
                        s_d.rdata = {{(32-ID_W){1'b0}}, SPURIOUS_ID};
                    end
                end
                default: s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata_o = s_q.rdata;

    // R5
    spurious_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ack_rd && s_q.rdata[ID_W-1:0] == SPURIOUS_ID) |-> (s_q.rdata[31:ID_W] == '0));

    // R4
    id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.ack_rd |-> (s_q.rdata[ID_W-1:0] == SPURIOUS_ID || s_q.rdata[ID_W-1:0] < ID_W'(NUM_IRQ)));

    // R6
    ack_marks_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ack_rd && s_q.rdata[ID_W-1:0] < ID_W'(NUM_IRQ)) |-> s_q.active[s_q.rdata[IDX_W-1:0]]);

    // R6
    active_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(s_q.active) <= $past($countones(s_q.active)) + 1);

    // R2
    irq_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (s_q.pmask != '0));

    // R8
    irq_needs_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (s_q.ctrl_en && dist_en_i));
endmodule

// File: tb/ciack_top_tb_top.sv
module ciack_top_tb_top;
    localparam int N  = 64;
    localparam int PW = 8;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dist_en = 1'b0;
    logic [N-1:0]    pend = '0;
    logic [N*PW-1:0] prio = '0;
    logic [16*CW-1:0] sgi_src = '0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [PW-1:0] m_prio [N];
    logic [CW-1:0] m_cpu [16];
    logic [N-1:0]  m_act = '0;
    logic          m_ctrl = 1'b0;
    logic [PW-1:0] m_mask = '0;

    always #10 clk = ~clk;

    ciack_top #(.NUM_IRQ(N), .PRIO_W(PW), .CPU_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .dist_en_i(dist_en), .pend_i(pend),
        .prio_i(prio), .sgi_src_i(sgi_src), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply();
        for (int i = 0; i < N; i++) prio[i*PW +: PW] = m_prio[i];
        for (int i = 0; i < 16; i++) sgi_src[i*CW +: CW] = m_cpu[i];
        #1;
    endtask

    function automatic logic [31:0] exp_ack();
        int best = 1 << PW;
        int id = -1;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && !m_act[i] && m_prio[i] < m_mask && int'(m_prio[i]) < best) begin
                best = int'(m_prio[i]);
                id = i;
            end
        end
        if (id < 0 || !m_ctrl || !dist_en) return 32'd1023;
        if (id < 16) return {19'b0, m_cpu[id], 10'(id)};
        return {22'b0, 10'(id)};
    endfunction

    function automatic logic exp_irq();
        return exp_ack() != 32'd1023;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) m_ctrl = d[0];
        if (a == 2'd1) m_mask = d[PW-1:0];
        if (a == 2'd3 && d[9:0] < 10'(N)) m_act[d[5:0]] = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic ack_check(input string tag);
        logic [31:0] e, got;
        e = exp_ack();
        rd(2'd2, got);
        check(tag, got, e);
        if (e != 32'd1023) m_act[e[5:0]] = 1'b1;
        #1;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) m_prio[i] = 8'hA0;
        for (int i = 0; i < 16; i++) m_cpu[i] = '0;
        apply();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 32'd0);
        rd(2'd0, v); check("R1 ctrl reset", v, 32'd0);
        rd(2'd1, v); check("R1 mask reset", v, 32'd0);
        pend = 64'h1; dist_en = 1'b1; #1;
        ack_check("R1 ack after reset");

        // R9 readback
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R9 ctrl readback", v, 32'd1);
        wr(2'd1, 32'h1234_56F0); rd(2'd1, v); check("R9 mask readback", v, 32'hF0);
        // R10 write to ack ignored, eoi reads zero
        wr(2'd2, 32'h0000_0005); rd(2'd1, v); check("R10 ack write ignored", v, 32'hF0);
        rd(2'd3, v); check("R10 eoi reads zero", v, 32'd0);

        // R2 R8 R6 single line
        pend = '0; pend[40] = 1'b1; m_prio[40] = 8'h10; apply();
        check("R8 irq single", {31'b0, irq}, 32'd1);
        ack_check("R4 ack single id 40");
        check("R6 irq after ack", {31'b0, irq}, 32'd0);
        ack_check("R6 reack spurious");
        wr(2'd3, 32'd40); #1;
        check("R7 irq after eoi", {31'b0, irq}, 32'd1);
        ack_check("R7 reack after eoi");
        wr(2'd3, {19'b0, 3'd7, 10'd40}); #1;
        check("R7 cpu bits ignored on eoi", {31'b0, irq}, 32'd1);

        // R2 mask equality
        m_prio[40] = 8'hF0; apply();
        check("R2 prio equal mask", {31'b0, irq}, 32'd0);
        m_prio[40] = 8'hEF; apply();
        check("R2 prio below mask", {31'b0, irq}, 32'd1);

        // R3 tie and priority
        pend = '0; pend[20] = 1'b1; pend[30] = 1'b1; pend[50] = 1'b1;
        m_prio[20] = 8'h50; m_prio[30] = 8'h50; m_prio[50] = 8'h60; apply();
        ack_check("R3 tie lower id");
        ack_check("R3 next tie");
        ack_check("R3 worse prio last");
        m_prio[50] = 8'h40;
        wr(2'd3, 32'd20); wr(2'd3, 32'd30); wr(2'd3, 32'd50); apply();
        ack_check("R3 lowest value wins");
        wr(2'd3, 32'd1023); #1;
        check("R7 out of range eoi", {31'b0, irq}, {31'b0, exp_irq()});
        ack_check("R7 state after bad eoi");
        wr(2'd3, 32'd20); wr(2'd3, 32'd30); wr(2'd3, 32'd50);

        // R4 SGI source field
        pend = '0; pend[5] = 1'b1; m_prio[5] = 8'h00; m_cpu[5] = 3'd6; apply();
        ack_check("R4 sgi source cpu");
        wr(2'd3, {19'b0, 3'd6, 10'd5});

        // R5 R8 enables
        dist_en = 1'b0; #1;
        check("R8 dist disabled irq", {31'b0, irq}, 32'd0);
        ack_check("R5 dist disabled ack");
        dist_en = 1'b1;
        wr(2'd0, 32'd0); #1;
        check("R8 ctrl disabled irq", {31'b0, irq}, 32'd0);
        ack_check("R5 ctrl disabled ack");
        wr(2'd0, 32'd1); #1;
        ack_check("R5 no activation while off");

        // random rounds
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            pend = {$urandom, $urandom};
            for (int i = 0; i < N; i++) m_prio[i] = 8'(($urandom % 9) << 5);
            for (int i = 0; i < 16; i++) m_cpu[i] = 3'($urandom);
            dist_en = ($urandom % 8) != 0;
            apply();
            check("R8 random irq", {31'b0, irq}, {31'b0, exp_irq()});
            if ($urandom % 2) ack_check("R3 random ack");
            if (($urandom % 3) == 0 && m_act != '0) begin
                int st = $urandom % N;
                for (int k = 0; k < N; k++) begin
                    int j = (st + k) % N;
                    if (m_act[j]) begin
                        wr(2'd3, {22'b0, 10'(j)});
                        break;
                    end
                end
            end
            if (($urandom % 40) == 0) wr(2'd1, 32'($urandom % 256));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule